// File: doc/BRIEF.md
# Add/Subtract/Multiply Arithmetic Unit

This block is a purely combinational arithmetic unit for two 8-bit unsigned operands. A function-select input picks one of two engines. The first is a gate-level 4x4 array multiplier that works on the low nibble of each operand. The second is an 8-bit ripple adder/subtractor. The chosen engine drives a single 8-bit result bus.

The multiplier forms its partial products with AND gates and sums them in rows of full adders. The adder/subtractor forms A−B by inverting B and setting the carry-in, which gives two's-complement subtraction. Each engine reaches the shared bus through its own array of tri-state buffers. The enable of each array comes straight from the function select, so the bus always has exactly one driver. A separate carry output reports the adder's carry-out.

Top module: `arith_unit`

## Requirements
- R1: With `fn_mul` = 1, `result` equals the 8-bit unsigned product of `op_a[3:0]` and `op_b[3:0]`.
- R2: With `fn_mul` = 1, bits [7:4] of either operand have no effect on `result`.
- R3: With `fn_mul` = 0 and `do_sub` = 0, `result` equals (`op_a` + `op_b`) mod 256 and `carry_out` equals bit 8 of the 9-bit sum.
- R4: With `fn_mul` = 0 and `do_sub` = 1, `result` equals (`op_a` − `op_b`) mod 256, computed as `op_a` + ~`op_b` + 1.
- R5: With `fn_mul` = 0 and `do_sub` = 1, `carry_out` is 1 exactly when `op_a` >= `op_b`, so it is 0 when a borrow occurs.
- R6: With `fn_mul` = 1, `do_sub` has no effect on `result`.
- R7: With `fn_mul` = 1, `carry_out` is 0.
- R8: Only the selected engine drives the result bus, so `result` always follows the selected function and never floats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| fn_mul | input | 1 | 1 selects the multiplier, 0 selects the adder/subtractor |
| do_sub | input | 1 | 1 selects subtraction, 0 selects addition (used by the add/sub engine only) |
| result | output | 8 | Shared result bus |
| carry_out | output | 1 | Adder carry-out; 0 in multiply mode |

## Verification
The embedded checks are immediate assertions inside combinational processes. They assume that every input is a known 0/1 value and that the inputs do not change while the logic settles. If an input is X or changes during evaluation, the arithmetic identities the checks compare could be seen in a transient state. The bench therefore drives all four inputs together at one clock edge, from fully specified values only, and reads the outputs at the opposite edge, half a period later. The multiply sweep sets the upper nibbles and the add/subtract control to random values, so the checks that those bits are ignored see real activity.

// File: rtl/arith_pkg.sv
// Package: shared widths for the arithmetic unit.
// Assumes the operand width is even so the multiplier nibble is half of it.
package arith_pkg;
    localparam int unsigned ALU_W = 8;
    localparam int unsigned MUL_N = ALU_W / 2;
endpackage

// File: rtl/bit_full_adder.sv
// Module: one-bit full adder built from gates.
// Assumes nothing beyond known inputs.
module bit_full_adder (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    // sum and carry of three bits
    always_comb begin
        s  = x ^ y ^ ci;
        co = (x & y) | (ci & (x ^ y));
    end
endmodule

// File: rtl/nibble_array_mult.sv
// Module: N x N unsigned array multiplier. AND gates form the partial
// products and rows of ripple full adders sum them.
// Assumes N >= 2. The product is 2N bits wide.
module nibble_array_mult #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0]   ma,
    input  logic [N-1:0]   mb,
    output logic [2*N-1:0] prod
);
    localparam int unsigned PW = 2 * N;

    logic [N-1:0] pp [N];
    logic [N-1:0] row_s [N];
    logic         row_c [N];

    // partial products: pp[i][j] = a[j] & b[i]
    for (genvar i = 0; i < N; i++) begin : g_pp
        for (genvar j = 0; j < N; j++) begin : g_pp_bit
            assign pp[i][j] = ma[j] & mb[i];
        end
    end

    // first row passes through with no carry
    assign row_s[0] = pp[0];
    assign row_c[0] = 1'b0;

    // later rows: add the shifted previous row to the next partial product
    for (genvar i = 1; i < N; i++) begin : g_row
        logic [N-1:0] opx;
        logic [N:0]   kc;
        assign kc[0] = 1'b0;
        for (genvar j = 0; j < N; j++) begin : g_cell
            if (j < N - 1) begin : g_mid
                assign opx[j] = row_s[i-1][j+1];
            end else begin : g_top
                assign opx[j] = row_c[i-1];
            end
            bit_full_adder u_fa (
                .x (opx[j]),
                .y (pp[i][j]),
                .ci(kc[j]),
                .s (row_s[i][j]),
                .co(kc[j+1])
            );
        end
        assign row_c[i] = kc[N];
    end

    // collect product bits: low bit of each row, then the last row's upper part
    for (genvar i = 0; i < N; i++) begin : g_lo
        assign prod[i] = row_s[i][0];
    end
    assign prod[PW-1:N] = {row_c[N-1], row_s[N-1][N-1:1]};

    // R1: a zero factor must give a zero product
    always_comb begin
        if (ma == '0 || mb == '0) begin
            zero_factor_chk: assert (prod == '0);
        end
    end

    // R1: multiplying by one must return the other factor
    always_comb begin
        if (mb == N'(1)) begin
            unit_factor_chk: assert (prod == PW'(ma));
        end
    end
endmodule

// File: rtl/ripple_addsub.sv
// Module: W-bit ripple adder/subtractor. sub=1 inverts y and sets the
// carry-in, giving x - y in two's complement.
// Assumes unsigned operands; the result wraps modulo 2**W.
module ripple_addsub #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W-1:0] y_eff;
    logic [W:0]   chain;

    // conditional inversion of the second operand
    always_comb y_eff = y ^ {W{sub}};

    assign chain[0] = sub;

    for (genvar i = 0; i < W; i++) begin : g_bit
        bit_full_adder u_fa (
            .x (x[i]),
            .y (y_eff[i]),
            .ci(chain[i]),
            .s (s[i]),
            .co(chain[i+1])
        );
    end

    assign co = chain[W];

    // R5: subtracting equal values gives zero with no borrow
    always_comb begin
        if (sub && x == y) begin
            sub_equal_chk: assert (s == '0 && co == 1'b1);
        end
    end

    // R5: carry after subtraction flags the absence of a borrow
    always_comb begin
        if (sub) begin
            sub_borrow_chk: assert (co == (x >= y));
        end
    end
endmodule

// File: rtl/bus_tristate_array.sv
// Module: W-bit tri-state buffer array onto a shared bus.
// Assumes the enables of all arrays on the same bus are mutually exclusive.
module bus_tristate_array #(
    parameter int unsigned W = 8
) (
    input  logic         en,
    input  logic [W-1:0] d,
    output wire  [W-1:0] y
);
    // one buffer per bit, high impedance when disabled
    for (genvar i = 0; i < W; i++) begin : g_buf
        assign y[i] = en ? d[i] : 1'bz;
    end
endmodule

// File: rtl/arith_unit.sv
// Module: top of the add/subtract/multiply arithmetic unit.
// Assumes known, settled inputs. The multiplier sees only the low
// nibbles. Each engine drives the shared bus through its own buffer array.
module arith_unit
    import arith_pkg::*;
(
    input  logic [7:0] op_a,
    input  logic [7:0] op_b,
    input  logic       fn_mul,
    input  logic       do_sub,
    output logic [7:0] result,
    output logic       carry_out
);
    logic [ALU_W-1:0] mul_out;
    logic [ALU_W-1:0] as_out;
    logic             as_co;
    logic             en_mul;
    logic             en_as;
    wire  [ALU_W-1:0] res_bus;

    // enables come straight from the function select
    always_comb begin
        en_mul = fn_mul;
        en_as  = ~fn_mul;
    end

    nibble_array_mult #(.N(MUL_N)) u_mul (
        .ma  (op_a[MUL_N-1:0]),
        .mb  (op_b[MUL_N-1:0]),
        .prod(mul_out)
    );

    ripple_addsub #(.W(ALU_W)) u_as (
        .x  (op_a),
        .y  (op_b),
        .sub(do_sub),
        .s  (as_out),
        .co (as_co)
    );

    bus_tristate_array #(.W(ALU_W)) u_tsb_mul (
        .en(en_mul),
        .d (mul_out),
        .y (res_bus)
    );

    bus_tristate_array #(.W(ALU_W)) u_tsb_as (
        .en(en_as),
        .d (as_out),
        .y (res_bus)
    );

    // bus to port; carry only reported in add/sub mode
    always_comb begin
        result    = res_bus;
        carry_out = as_co & ~fn_mul;
    end

    // R1: in multiply mode the bus carries the nibble product
    always_comb begin
        if (fn_mul) begin
            mul_result_chk: assert (result == ALU_W'(op_a[MUL_N-1:0]) * ALU_W'(op_b[MUL_N-1:0]));
        end
    end

    // R8: in add/sub mode the bus carries the adder output only
    always_comb begin
        if (!fn_mul) begin
            as_result_chk: assert (result == as_out);
        end
    end

    // R7: no carry reported in multiply mode
    always_comb begin
        if (fn_mul) begin
            mul_carry_chk: assert (carry_out == 1'b0);
        end
    end
endmodule

// File: tb/tb_arith_unit.sv
module tb_arith_unit;
    typedef struct {
        logic [7:0] a;
        logic [7:0] b;
        logic       fm;
        logic       sb;
        logic [7:0] er;
        logic       ec;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic       fn_mul = 1'b0;
    logic       do_sub = 1'b0;
    logic [7:0] result;
    logic       carry_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    item_t sbq[$];

    always #10 clk = ~clk;

    arith_unit dut (
        .op_a(op_a), .op_b(op_b), .fn_mul(fn_mul), .do_sub(do_sub),
        .result(result), .carry_out(carry_out)
    );

    // driver: apply inputs at the falling edge and push the expected item
    task automatic drive(input logic [7:0] a, input logic [7:0] b,
                         input logic fm, input logic sb, input string tag);
        item_t it;
        logic [8:0] w;
        @(negedge clk);
        op_a = a; op_b = b; fn_mul = fm; do_sub = sb;
        it.a = a; it.b = b; it.fm = fm; it.sb = sb; it.tag = tag;
        if (fm) begin
            it.er = 8'(a[3:0]) * 8'(b[3:0]);
            it.ec = 1'b0;
        end else if (sb) begin
            w = {1'b0, a} + {1'b0, ~b} + 9'd1;
            it.er = w[7:0];
            it.ec = (a >= b);
        end else begin
            w = {1'b0, a} + {1'b0, b};
            it.er = w[7:0];
            it.ec = w[8];
        end
        sbq.push_back(it);
    endtask

    // monitor: pop and compare at the rising edge, half a period after driving
    always @(posedge clk) begin
        if (rst_n && sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            n_cmp++;
            if (result !== it.er || carry_out !== it.ec) begin
                n_bad++;
                $display("FAIL %s a=%h b=%h mul=%b sub=%b: got res=%h c=%b, expected res=%h c=%b",
                         it.tag, it.a, it.b, it.fm, it.sb, result, carry_out, it.er, it.ec);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset state: zero inputs, add mode
        drive(8'h00, 8'h00, 1'b0, 1'b0, "R3 reset-zero");
        // R1: full nibble sweep; R2 random upper bits; R6 random do_sub
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                logic [7:0] ua, ub;
                ua = 8'($urandom);
                ub = 8'($urandom);
                drive({ua[7:4], 4'(i)}, {ub[7:4], 4'(j)}, 1'b1, 1'($urandom), "R1/R2/R6/R7 mul");
            end
        end
        // R2: upper bits alone changed, product identical
        drive(8'h0F, 8'h0F, 1'b1, 1'b0, "R2 mul base");
        drive(8'hFF, 8'hAF, 1'b1, 1'b0, "R2 mul high bits");
        // R6: do_sub flips, product unchanged
        drive(8'h37, 8'h25, 1'b1, 1'b1, "R6 mul sub=1");
        // R3: corner additions
        drive(8'hFF, 8'h01, 1'b0, 1'b0, "R3 wrap");
        drive(8'h80, 8'h80, 1'b0, 1'b0, "R3 carry");
        drive(8'h7F, 8'h00, 1'b0, 1'b0, "R3 no carry");
        // R4/R5: corner subtractions
        drive(8'h05, 8'h05, 1'b0, 1'b1, "R4/R5 equal");
        drive(8'h00, 8'h01, 1'b0, 1'b1, "R4/R5 borrow");
        drive(8'hFF, 8'h00, 1'b0, 1'b1, "R4/R5 max");
        drive(8'h10, 8'hF0, 1'b0, 1'b1, "R4/R5 wrap");
        // R3, R4, R5, R8: random add and subtract
        for (int k = 0; k < 128; k++) begin
            drive(8'($urandom), 8'($urandom), 1'b0, 1'(k & 1), "R3/R4/R5/R8 addsub");
        end
        // R8: alternate engines on the same operands
        for (int k = 0; k < 16; k++) begin
            logic [7:0] a, b;
            a = 8'($urandom);
            b = 8'($urandom);
            drive(a, b, 1'b1, 1'b0, "R8 mul side");
            drive(a, b, 1'b0, 1'b0, "R8 add side");
        end
        wait (sbq.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule